// File: doc/BRIEF.md
# Zoned External Bus Controller

This block runs accesses on an external asynchronous memory and peripheral bus on behalf of a simple internal request port. A request carries an address, a read/write flag, an I/O-space flag and write data. The controller accepts it when idle and decodes the three top address bits into a zone. It drives one of three active-low chip selects for a programmed number of wait states, optionally stretched by an external ready input. It then reports completion with a one-cycle done pulse and the captured read data.

Five zones exist: 0, 1, 2, 6 and 7. Zones 0 and 1 share one chip select, zone 2 has its own, and zones 6 and 7 share the third. Each zone has its own wait count and ready-sampling enable, set through a small configuration write port. A mode bit is loaded from a pin while reset is held and can be rewritten by software. It switches the top zone in or out, so that accesses to that region can be left to an internal boot memory. Requests to absent zones, to a switched-out top zone, or to I/O space complete at once without touching the bus.

Top module: `xbz_ctrl`

## Requirements
- R1: Zone = req_addr_i[ADDR_W-1:ADDR_W-3]. Zones 0 and 1 drive xcs_n_o[0] low, zone 2 drives xcs_n_o[1], and zones 6 and 7 drive xcs_n_o[2]. Zones 3, 4 and 5 are unmapped. At most one chip select is low at any time.
- R2: A write with cfg_sel_i = k (0..7, bit 3 clear) to a present zone sets that zone's wait count from cfg_wdata_i[WS_W-1:0] and its ready enable from cfg_wdata_i[WS_W]. After reset every zone has the all-ones wait count and ready sampling off.
- R3: With ready ignored, the chip select stays low for exactly max(wait,1) cycles, so a wait count of zero acts as one. It goes low only from the all-high state.
- R4: With ready sampling on, ready is sampled on each clock edge once the wait states have run out, and the access ends on the first such edge where xready_i is high.
- R5: With ready sampling off, xready_i has no effect on access length.
- R6: req_done_o is high for exactly the one cycle after the completing edge, and in that cycle all chip selects and strobes are high. Requests are accepted only while idle.
- R7: During a bus read xrd_n_o is low and xdata_i is captured into req_rdata_o at the completing edge. During a bus write xwr_n_o is low, xdata_oe_o is high and xdata_o holds the request data. A write completes with req_rdata_o = 0.
- R8: The mode bit follows mode_pin_i while rst_ni is low. When it is 1, zone 7 is mapped to xcs_n_o[2]. When it is 0, zone 7 is treated as unmapped.
- R9: A configuration write with cfg_sel_i = 8 sets the mode bit from cfg_wdata_i[0]. It changes only zone 7's mapping.
- R10: An access that is I/O space, unmapped or to a switched-out zone asserts no chip select and completes one cycle after acceptance with req_rdata_o = 0.
- R11: While reset is held and just after it, all chip selects and strobes are high, req_done_o is 0 and req_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_pin_i | input | 1 | Boot mode level, loaded while in reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 4 | Configuration target: zone 0..7 or 8 for mode |
| cfg_wdata_i | input | WS_W+1 | Wait count and ready enable, or mode in bit 0 |
| req_valid_i | input | 1 | Request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | Request targets I/O space |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Request write data |
| req_done_o | output | 1 | One-cycle completion pulse |
| req_rdata_o | output | DATA_W | Read data of the last completed access |
| xaddr_o | output | ADDR_W | External address |
| xdata_o | output | DATA_W | External write data |
| xdata_oe_o | output | 1 | External data output enable |
| xdata_i | input | DATA_W | External read data |
| xrd_n_o | output | 1 | External read strobe, active low |
| xwr_n_o | output | 1 | External write strobe, active low |
| xcs_n_o | output | 3 | Chip selects, active low |
| xready_i | input | 1 | External ready |

## Verification
The assertions check on every cycle that at most one chip select is low, that chip selects go low only from the all-high state and release only with done, that done is a single-cycle pulse with all strobes released, and that exactly one strobe is active during an access. They also check that I/O-space requests and top-zone requests with the mode bit clear never reach a chip select. Only the bench scenarios can show the access lengths for each wait count and ready pattern, the zero-means-one rule, the reset defaults, the read data capture and write data drive, and the effect of the mode bit loaded at reset versus rewritten by software.

// File: rtl/xbz_pkg.sv
package xbz_pkg;
  localparam int unsigned ZONE_W    = 3;
  localparam int unsigned NUM_SLOTS = 1 << ZONE_W;
  localparam int unsigned NUM_CS    = 3;
  localparam int unsigned SEL_W     = ZONE_W + 1;
  localparam logic [NUM_SLOTS-1:0] ZONE_PRESENT = 8'b1100_0111;
  localparam logic [ZONE_W-1:0]    TOP_ZONE     = 3'd7;
  localparam logic [SEL_W-1:0]     SEL_MODE     = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_DONE} xbz_state_e;

  function automatic logic [1:0] cs_index(logic [ZONE_W-1:0] zone);
    case (zone)
      3'd0, 3'd1: cs_index = 2'd0;
      3'd2:       cs_index = 2'd1;
      default:    cs_index = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/xbz_cfg_regs.sv
module xbz_cfg_regs
  import xbz_pkg::*;
#(
  parameter int unsigned WS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_pin_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [WS_W:0]     cfg_wdata_i,
  input  logic [ZONE_W-1:0] rd_zone_i,
  output logic [WS_W-1:0]   wait_o,
  output logic              ready_en_o,
  output logic              mode_o
);
  logic [WS_W-1:0] wait_q [NUM_SLOTS];
  logic            ren_q  [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    if (ZONE_PRESENT[k]) begin : g_on
      logic hit;
      assign hit = cfg_we_i && !cfg_sel_i[SEL_W-1] &&
                   (cfg_sel_i[ZONE_W-1:0] == ZONE_W'(k));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wait_q[k] <= '1;
          ren_q[k]  <= 1'b0;
        end else if (hit) begin
          wait_q[k] <= cfg_wdata_i[WS_W-1:0];
          ren_q[k]  <= cfg_wdata_i[WS_W];
        end
      end
    end else begin : g_off
      assign wait_q[k] = '0;
      assign ren_q[k]  = 1'b0;
    end
  end

  // mode bit tracks the pin while reset is held
  logic mode_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                mode_q <= mode_pin_i;
    else if (cfg_we_i && cfg_sel_i == SEL_MODE) mode_q <= cfg_wdata_i[0];
  end

  assign wait_o     = wait_q[rd_zone_i];
  assign ready_en_o = ren_q[rd_zone_i];
  assign mode_o     = mode_q;
endmodule

// File: rtl/xbz_decode.sv
module xbz_decode
  import xbz_pkg::*;
(
  input  logic [ZONE_W-1:0] zone_i,
  input  logic              io_i,
  input  logic              mode_i,
  output logic              hit_o,
  output logic [1:0]        cs_idx_o
);
  always_comb begin
    hit_o    = !io_i && ZONE_PRESENT[zone_i] && ((zone_i != TOP_ZONE) || mode_i);
    cs_idx_o = cs_index(zone_i);
  end
endmodule

// File: rtl/xbz_timer.sv
module xbz_timer #(
  parameter int unsigned WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WS_W-1:0] load_val_i,
  input  logic            step_i,
  output logic            expired_o
);
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= WS_W'(1);
    else if (load_i)                 cnt_q <= (load_val_i == '0) ? WS_W'(1) : load_val_i;
    else if (step_i && !expired_o)   cnt_q <= cnt_q - WS_W'(1);
  end

  assign expired_o = (cnt_q <= WS_W'(1));
endmodule

// File: rtl/xbz_ctrl.sv
module xbz_ctrl
  import xbz_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WS_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_pin_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_sel_i,
  input  logic [WS_W:0]     cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              req_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_done_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic [ADDR_W-1:0] xaddr_o,
  output logic [DATA_W-1:0] xdata_o,
  output logic              xdata_oe_o,
  input  logic [DATA_W-1:0] xdata_i,
  output logic              xrd_n_o,
  output logic              xwr_n_o,
  output logic [2:0]        xcs_n_o,
  input  logic              xready_i
);
  localparam int unsigned ZLSB = ADDR_W - ZONE_W;

  xbz_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, ren_q;
  logic [1:0]        cs_idx_q;

  logic [ZONE_W-1:0] zone_w;
  logic [WS_W-1:0]   wait_w;
  logic              ren_w, mode_w, hit_w, expired_w;
  logic [1:0]        cs_idx_w;
  logic              accept, in_access, finish;

  assign zone_w    = req_addr_i[ADDR_W-1:ZLSB];
  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign in_access = (state_q == ST_ACCESS);

  xbz_cfg_regs #(.WS_W(WS_W)) u_cfg (
    .clk_i, .rst_ni, .mode_pin_i, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .rd_zone_i(zone_w), .wait_o(wait_w), .ready_en_o(ren_w), .mode_o(mode_w)
  );

  xbz_decode u_dec (
    .zone_i(zone_w), .io_i(req_io_i), .mode_i(mode_w),
    .hit_o(hit_w), .cs_idx_o(cs_idx_w)
  );

  xbz_timer #(.WS_W(WS_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(accept && hit_w), .load_val_i(wait_w),
    .step_i(in_access), .expired_o(expired_w)
  );

  assign finish = in_access && expired_w && (!ren_q || xready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      we_q     <= 1'b0;
      ren_q    <= 1'b0;
      cs_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q   <= req_addr_i;
          wdata_q  <= req_wdata_i;
          we_q     <= req_we_i;
          ren_q    <= ren_w;
          cs_idx_q <= cs_idx_w;
          if (hit_w) state_q <= ST_ACCESS;
          else begin
            rdata_q <= '0;
            state_q <= ST_DONE;
          end
        end
        ST_ACCESS: if (finish) begin
          rdata_q <= we_q ? '0 : xdata_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign xcs_n_o[c] = !(in_access && (cs_idx_q == 2'(c)));
  end

  assign xrd_n_o     = !(in_access && !we_q);
  assign xwr_n_o     = !(in_access && we_q);
  assign xdata_oe_o  = in_access && we_q;
  assign xdata_o     = wdata_q;
  assign xaddr_o     = addr_q;
  assign req_done_o  = (state_q == ST_DONE);
  assign req_rdata_o = rdata_q;
endmodule

// File: rtl/xbz_ctrl_chk.sv
module xbz_ctrl_chk
  import xbz_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_io_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_done_o,
  input logic              xrd_n_o,
  input logic              xwr_n_o,
  input logic [2:0]        xcs_n_o,
  input xbz_state_e        state,
  input logic              mode
);
  logic idle, cs_any;
  assign idle   = (state == ST_IDLE);
  assign cs_any = !(&xcs_n_o);

  assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~xcs_n_o));

  assert_cs_from_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_any && !$stable(xcs_n_o)) |-> $past(&xcs_n_o));

  assert_cs_release_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_any) && !cs_any) |-> req_done_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);

  assert_done_idle_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> (!cs_any && xrd_n_o && xwr_n_o));

  assert_one_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_any |-> (xrd_n_o != xwr_n_o));

  assert_io_no_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_io_i && idle) |=> (!cs_any && req_done_o));

  assert_top_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && idle && !mode && req_addr_i[ADDR_W-1 -: 3] == TOP_ZONE)
      |=> (!cs_any && req_done_o));
endmodule

bind xbz_ctrl xbz_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_io_i(req_io_i), .req_addr_i(req_addr_i), .req_done_o(req_done_o),
  .xrd_n_o(xrd_n_o), .xwr_n_o(xwr_n_o), .xcs_n_o(xcs_n_o),
  .state(state_q), .mode(mode_w)
);

// File: tb/xbz_ctrl_test.sv
`timescale 1ns/1ps
module xbz_ctrl_test;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int WS_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pin = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [WS_W:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_we = 1'b0, req_io = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_done;
  logic [DATA_W-1:0] req_rdata;
  logic [ADDR_W-1:0] xaddr;
  logic [DATA_W-1:0] xdata_out, xdata_in;
  logic xdata_oe, xrd_n, xwr_n, xready = 1'b0;
  logic [2:0] xcs_n;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  assign xdata_in = xaddr[15:0] ^ 16'hA5A5;

  xbz_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_pin_i(mode_pin),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_io_i(req_io),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_done_o(req_done), .req_rdata_o(req_rdata),
    .xaddr_o(xaddr), .xdata_o(xdata_out), .xdata_oe_o(xdata_oe),
    .xdata_i(xdata_in), .xrd_n_o(xrd_n), .xwr_n_o(xwr_n),
    .xcs_n_o(xcs_n), .xready_i(xready)
  );

  typedef struct packed {
    logic [2:0] zone;
    logic       we;
    logic       io;
    logic [3:0] ws;
    logic       ren;
    logic [7:0] rdly;
    logic [1:0] exp_cs;   // 3 = none
    logic [7:0] exp_cyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 4'd3, 1'b0, 8'd0, 2'd0, 8'd3},  // R1 R3
    '{3'd1, 1'b0, 1'b0, 4'd0, 1'b0, 8'd0, 2'd0, 8'd1},  // R3 zero acts as one
    '{3'd2, 1'b1, 1'b0, 4'd2, 1'b0, 8'd0, 2'd1, 8'd2},  // R7 write
    '{3'd6, 1'b0, 1'b0, 4'd1, 1'b1, 8'd4, 2'd2, 8'd5},  // R4 ready stretch
    '{3'd7, 1'b0, 1'b0, 4'd5, 1'b1, 8'd2, 2'd2, 8'd5},  // R4 ready early, R8
    '{3'd2, 1'b0, 1'b0, 4'd2, 1'b0, 8'd6, 2'd1, 8'd2},  // R5 ready ignored
    '{3'd3, 1'b0, 1'b0, 4'd0, 1'b0, 8'd0, 2'd3, 8'd0},  // R10 unmapped
    '{3'd5, 1'b1, 1'b0, 4'd0, 1'b0, 8'd0, 2'd3, 8'd0},  // R10 unmapped write
    '{3'd0, 1'b0, 1'b1, 4'd2, 1'b0, 8'd0, 2'd3, 8'd0},  // R10 io space
    '{3'd6, 1'b1, 1'b0, 4'd4, 1'b1, 8'd0, 2'd2, 8'd4}   // R4 ready high at once
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] sel, input logic [WS_W:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_access(input logic [2:0] zone, input logic we, input logic io,
                           input int rdly, input logic [16:0] off,
                           output int cyc, output int cs_id,
                           output logic [DATA_W-1:0] rd, output bit wr_ok, output bit done_seen);
    cyc = 0; cs_id = 3; wr_ok = 1'b1; done_seen = 1'b0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_io = io;
    req_addr = {zone, off}; req_wdata = 16'h3C00 ^ off[15:0];
    xready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (req_done) begin
        done_seen = 1'b1;
        rd = req_rdata;
        break;
      end
      if (xcs_n != 3'b111) begin
        cyc++;
        for (int c = 0; c < 3; c++) if (!xcs_n[c]) cs_id = c;
        if (we && !(xdata_oe && !xwr_n && xrd_n && xdata_out == (16'h3C00 ^ off[15:0])))
          wr_ok = 1'b0;
        if (!we && (xrd_n || !xwr_n || xdata_oe)) wr_ok = 1'b0;
      end
      xready = (cyc > rdly);
      @(negedge clk);
    end
    xready = 1'b0;
  endtask

  task automatic run_one(input string tag, input logic [2:0] zone, input logic we,
                         input logic io, input int rdly, input logic [16:0] off,
                         input int exp_cs, input int exp_cyc);
    int cyc, cs_id;
    logic [DATA_W-1:0] rd, exp_rd;
    bit wr_ok, dn;
    do_access(zone, we, io, rdly, off, cyc, cs_id, rd, wr_ok, dn);
    exp_rd = (exp_cs == 3 || we) ? '0 : (off[15:0] ^ 16'hA5A5);
    check(dn, {tag, " done"}, int'(dn), 1);
    check(cs_id == exp_cs, {tag, " chip select"}, cs_id, exp_cs);
    check(cyc == exp_cyc, {tag, " access cycles"}, cyc, exp_cyc);
    check(rd == exp_rd, {tag, " R7 rdata"}, int'(rd), int'(exp_rd));
    check(wr_ok, {tag, " R7 strobes/data"}, int'(wr_ok), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check(xcs_n == 3'b111 && xrd_n && xwr_n, "R11 bus idle in reset", int'(xcs_n), 7);
    check(!req_done && req_rdata == '0, "R11 done/rdata in reset", int'(req_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(xcs_n == 3'b111 && !req_done, "R11 idle after reset", int'(xcs_n), 7);

    // R2 reset defaults: all-ones wait, ready off
    run_one("R2 default timing", 3'd0, 1'b0, 1'b0, 40, 17'h0123, 0, 15);

    for (int v = 0; v < NV; v++) begin
      if (!VECS[v].io && (VECS[v].zone inside {3'd0, 3'd1, 3'd2, 3'd6, 3'd7}))
        cfg_write({1'b0, VECS[v].zone}, {VECS[v].ren, VECS[v].ws});
      run_one($sformatf("R1 vec%0d", v), VECS[v].zone, VECS[v].we, VECS[v].io,
              int'(VECS[v].rdly), 17'(16'h1000 + v * 16'h0111),
              int'(VECS[v].exp_cs), int'(VECS[v].exp_cyc));
    end

    // R9 software clears mode: zone 7 switched out, zone 6 unchanged
    cfg_write(4'd8, 5'b00000);
    run_one("R9 top off", 3'd7, 1'b0, 1'b0, 0, 17'h0777, 3, 0);
    run_one("R9 zone6 kept", 3'd6, 1'b0, 1'b0, 0, 17'h0666, 2, 4);
    // R9 software sets mode again
    cfg_write(4'd8, 5'b00001);
    run_one("R9 top on", 3'd7, 1'b0, 1'b0, 0, 17'h0701, 2, 5);

    // R8 reset with mode pin low: zone 7 disabled from the start
    @(negedge clk);
    rst_n = 1'b0; mode_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mode_pin = 1'b1;   // pin level after reset must not matter
    @(negedge clk);
    run_one("R8 pin low", 3'd7, 1'b0, 1'b0, 0, 17'h0711, 3, 0);
    run_one("R8 zone0 defaults", 3'd0, 1'b1, 1'b0, 0, 17'h0222, 0, 15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule